// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by fetching one page table entry from memory. A requester presents a 32-bit virtual address, an access kind (read, write or execute), a privilege flag (user or kernel) and the physical base of the current table. The block splits the address into a page number and an in-page offset. It forms the entry address by scaling the page number to an entry index from the base, and issues a single read on a plain valid/data memory port.

When the entry returns, the block decodes its residency bit, its rights field and its user-access bit. It then reports one of three outcomes: a translated physical address, a page fault, or a protection fault. Only one translation is in flight at a time. The request port shows ready only while the block is idle, and each result is given as a one-cycle response pulse.

Top module: `vpt_walker`

## Requirements
- R1: Out of reset reqReady is 1 and memReqValid and rspValid are 0.
- R2: A request is taken at a clock edge where reqValid and reqReady are both 1. reqReady stays 0 from the next cycle until the cycle after the rspValid pulse. A request offered while busy is ignored and leaves the result of the current translation unchanged.
- R3: From the cycle after acceptance, memReqValid is 1 and memReqAddr holds tableBase + 4 * vaddr[31:12], taken modulo 2^24. Both stay steady until the cycle in which memRspValid is seen.
- R4: Entry bit 0 is the residency bit. When it is 0 the result is status 01 (page fault) with rspPaddr 0, even if the rights or privilege checks would also fail.
- R5: Entry bits 2:1 give the rights: 00 allows read, 01 allows read and write, 10 allows execute only, and 11 allows nothing. The access code on reqAccess is 00 read, 01 write, 10 execute, and 11 matches no right. A resident entry whose rights do not allow the access gives status 10 (protection fault) with rspPaddr 0.
- R6: Entry bit 3 marks a page as user-accessible. A user-mode request (reqUser=1) to a page with bit 3 clear gives status 10. A kernel request (reqUser=0) does not look at bit 3.
- R7: When all checks pass, status is 00 and rspPaddr is {entry[31:20], vaddr[11:0]}, so the page offset passes through unchanged.
- R8: rspValid is a one-cycle pulse in the second cycle after the edge that captures memRspValid. A memRspValid given while no entry read is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqAccess | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| reqUser | input | 1 | 1 for user mode, 0 for kernel mode |
| tableBase | input | 24 | Physical start of the page table |
| memReqValid | output | 1 | Entry read outstanding |
| memReqAddr | output | 24 | Byte address of the entry |
| memRspValid | input | 1 | Entry data present |
| memRspData | input | 32 | Entry contents |
| rspValid | output | 1 | Result pulse |
| rspStatus | output | 2 | 00 ok, 01 page fault, 10 protection fault |
| rspPaddr | output | 24 | Physical address, 0 on a fault |

## Verification
Random entries, addresses, access kinds and privilege flags are mixed so that all three outcomes occur often. Each result is compared with a bench model of the rights table, which separates rights decoding errors from privilege errors and from offset or page-number splicing errors. Directed cases set up a non-resident entry whose rights would also fail, to expose wrong fault priority. Other directed cases use a base near the top of the address space to test address wrap, a zero-cycle and a multi-cycle memory latency to test the handshake, and stray memory responses and busy-time requests to show that the block ignores them.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_CHECK = 2'd2,
    ST_DONE  = 2'd3
  } walkState_t;

  typedef struct packed {
    logic takeReq;
    logic takePte;
    logic takeResult;
  } walkStrobe_t;

  localparam logic [1:0] RES_OK   = 2'b00;
  localparam logic [1:0] RES_PAGE = 2'b01;
  localparam logic [1:0] RES_PROT = 2'b10;

  localparam logic [1:0] ACC_READ  = 2'b00;
  localparam logic [1:0] ACC_WRITE = 2'b01;
  localparam logic [1:0] ACC_EXEC  = 2'b10;

  localparam logic [1:0] RGT_RO = 2'b00;
  localparam logic [1:0] RGT_RW = 2'b01;
  localparam logic [1:0] RGT_XO = 2'b10;
endpackage

// File: rtl/vpt_ctrl.sv
module vpt_ctrl
  import vpt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRspValid,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        rspValid,
  output walkStrobe_t strobe
);
  walkState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: if (reqValid) begin
        strobe.takeReq = 1'b1;
        stateD = ST_READ;
      end
      ST_READ: if (memRspValid) begin
        strobe.takePte = 1'b1;
        stateD = ST_CHECK;
      end
      ST_CHECK: begin
        strobe.takeResult = 1'b1;
        stateD = ST_DONE;
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign reqReady    = (stateQ == ST_IDLE);
  assign memReqValid = (stateQ == ST_READ);
  assign rspValid    = (stateQ == ST_DONE);

  // R2: a taken request drops ready on the next cycle
  a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady && memReqValid);
  // R3: read stays raised until answered
  a_r3_read_held: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memRspValid |=> memReqValid);
  // R8: result pulse lasts one cycle and is followed by idle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid && reqReady);
  // R8: answer leads to the pulse two cycles later
  a_r8_pulse_timing: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memRspValid |=> !rspValid ##1 rspValid);
endmodule

// File: rtl/vpt_dpath.sv
module vpt_dpath
  import vpt_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 24,
  parameter int PAGE_BITS = 12,
  parameter int PTE_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [1:0]        reqAccess,
  input  logic              reqUser,
  input  logic [PA_W-1:0]   tableBase,
  input  logic [PTE_W-1:0]  memRspData,
  output logic [PA_W-1:0]   memReqAddr,
  output logic [1:0]        rspStatus,
  output logic [PA_W-1:0]   rspPaddr
);
  localparam int VPN_W       = VA_W - PAGE_BITS;
  localparam int PPN_W       = PA_W - PAGE_BITS;
  localparam int PPN_LSB     = PTE_W - PPN_W;
  localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);
  localparam int IDX_W       = VPN_W + ENTRY_SHIFT;

  logic [VA_W-1:0]  vaddrQ;
  logic [1:0]       accessQ;
  logic             userQ;
  logic [PA_W-1:0]  baseQ;
  logic [PTE_W-1:0] pteQ;
  logic [1:0]       statusQ;
  logic [PA_W-1:0]  paddrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaddrQ  <= '0;
      accessQ <= '0;
      userQ   <= 1'b0;
      baseQ   <= '0;
    end else if (strobe.takeReq) begin
      vaddrQ  <= reqVaddr;
      accessQ <= reqAccess;
      userQ   <= reqUser;
      baseQ   <= tableBase;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pteQ <= '0;
    else if (strobe.takePte) pteQ <= memRspData;
  end

  // entry address: base plus page number scaled to entry size
  logic [IDX_W-1:0] entryIdx;
  logic [PA_W-1:0]  entryOff;
  assign entryIdx   = {vaddrQ[VA_W-1:PAGE_BITS], {ENTRY_SHIFT{1'b0}}};
  assign entryOff   = PA_W'(entryIdx);
  assign memReqAddr = baseQ + entryOff;

  // entry decode and permission check
  logic       resident, userPage, rightOk, privOk;
  logic [1:0] rights;
  logic [1:0] statusD;
  logic [PA_W-1:0] paddrD;

  assign resident = pteQ[0];
  assign rights   = pteQ[2:1];
  assign userPage = pteQ[3];
  assign privOk   = !userQ || userPage;

  always_comb begin
    unique case (accessQ)
      ACC_READ:  rightOk = (rights == RGT_RO) || (rights == RGT_RW);
      ACC_WRITE: rightOk = (rights == RGT_RW);
      ACC_EXEC:  rightOk = (rights == RGT_XO);
      default:   rightOk = 1'b0;
    endcase
  end

  always_comb begin
    if (!resident)                statusD = RES_PAGE;
    else if (!(rightOk && privOk)) statusD = RES_PROT;
    else                          statusD = RES_OK;
    paddrD = (statusD == RES_OK)
           ? {pteQ[PTE_W-1:PPN_LSB], vaddrQ[PAGE_BITS-1:0]} : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= RES_OK;
      paddrQ  <= '0;
    end else if (strobe.takeResult) begin
      statusQ <= statusD;
      paddrQ  <= paddrD;
    end
  end

  assign rspStatus = statusQ;
  assign rspPaddr  = paddrQ;

  // R3: entry address only moves when a new request is taken
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.takeReq |=> $stable(memReqAddr));
  // R2: captured request is not disturbed while busy
  a_r2_req_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takePte |=> $stable(vaddrQ) && $stable(accessQ) && $stable(userQ));
endmodule

// File: rtl/vpt_walker.sv
module vpt_walker
  import vpt_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 24,
  parameter int PAGE_BITS = 12,
  parameter int PTE_W     = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [1:0]       reqAccess,
  input  logic             reqUser,
  input  logic [PA_W-1:0]  tableBase,
  output logic             memReqValid,
  output logic [PA_W-1:0]  memReqAddr,
  input  logic             memRspValid,
  input  logic [PTE_W-1:0] memRspData,
  output logic             rspValid,
  output logic [1:0]       rspStatus,
  output logic [PA_W-1:0]  rspPaddr
);
  walkStrobe_t strobe;

  vpt_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRspValid(memRspValid),
    .reqReady(reqReady), .memReqValid(memReqValid), .rspValid(rspValid),
    .strobe(strobe)
  );

  vpt_dpath #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .PTE_W(PTE_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVaddr(reqVaddr),
    .reqAccess(reqAccess), .reqUser(reqUser), .tableBase(tableBase),
    .memRspData(memRspData), .memReqAddr(memReqAddr),
    .rspStatus(rspStatus), .rspPaddr(rspPaddr)
  );

  // R4/R5: a faulting result never carries an address
  a_r4_fault_no_addr: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspStatus != RES_OK |-> rspPaddr == '0);
  // R5: status code 11 is never produced
  a_r5_status_legal: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> rspStatus != 2'b11);
  // R1: idle means nothing outstanding
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReqValid && !rspValid);
endmodule

// File: tb/tb_vpt_walker.sv
module tb_vpt_walker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic        reqUser = 1'b0;
  logic [23:0] tableBase = '0;
  logic        memReqValid;
  logic [23:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        rspValid;
  logic [1:0]  rspStatus;
  logic [23:0] rspPaddr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  vpt_walker dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqAccess(reqAccess), .reqUser(reqUser),
    .tableBase(tableBase), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .rspValid(rspValid),
    .rspStatus(rspStatus), .rspPaddr(rspPaddr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] expStatus(input logic [31:0] pte,
                                           input logic [1:0] acc, input bit usr);
    bit allow;
    case (acc)
      2'b00:   allow = (pte[2:1] == 2'b00) || (pte[2:1] == 2'b01);
      2'b01:   allow = (pte[2:1] == 2'b01);
      2'b10:   allow = (pte[2:1] == 2'b10);
      default: allow = 1'b0;
    endcase
    if (usr && !pte[3]) allow = 1'b0;
    if (!pte[0]) return 2'b01;
    return allow ? 2'b00 : 2'b10;
  endfunction

  function automatic logic [23:0] expPaddr(input logic [31:0] pte,
                                           input logic [31:0] va, input logic [1:0] st);
    return (st == 2'b00) ? {pte[31:20], va[11:0]} : 24'h0;
  endfunction

  function automatic logic [23:0] expEntry(input logic [23:0] base, input logic [31:0] va);
    logic [23:0] off;
    off = {va[31:12], 2'b00};
    return base + off;
  endfunction

  task automatic doTxn(input logic [31:0] va, input logic [1:0] acc, input bit usr,
                       input logic [23:0] base, input logic [31:0] pte,
                       input int delay, input bit junk, input string tag);
    logic [23:0] ea;
    logic [1:0]  st;
    ea = expEntry(base, va);
    st = expStatus(pte, acc, usr);
    @(negedge clk);
    chk(reqReady == 1'b1, "R2 ready before request", 32'(reqReady), 32'd1);
    reqValid = 1'b1; reqVaddr = va; reqAccess = acc; reqUser = usr; tableBase = base;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (junk) begin
      reqValid = 1'b1; reqVaddr = ~va; reqAccess = ~acc; reqUser = ~usr;
      tableBase = base ^ 24'h5A5A5A;
    end
    chk(reqReady == 1'b0, "R2 busy after accept", 32'(reqReady), 32'd0);
    chk(memReqValid == 1'b1, "R3 read raised", 32'(memReqValid), 32'd1);
    chk(memReqAddr == ea, {"R3 entry address ", tag}, 32'(memReqAddr), 32'(ea));
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      chk(memReqValid && memReqAddr == ea, "R3 read held",
          32'(memReqAddr), 32'(ea));
    end
    memRspValid = 1'b1; memRspData = pte;
    @(negedge clk);
    memRspValid = 1'b0; memRspData = $urandom;
    reqValid = 1'b0;
    chk(rspValid == 1'b0 && memReqValid == 1'b0, "R8 no pulse yet",
        32'(rspValid), 32'd0);
    @(negedge clk);
    chk(rspValid == 1'b1, "R8 pulse", 32'(rspValid), 32'd1);
    chk(rspStatus == st, {"R4 R5 R6 status ", tag}, 32'(rspStatus), 32'(st));
    chk(rspPaddr == expPaddr(pte, va, st), {"R7 paddr ", tag},
        32'(rspPaddr), 32'(expPaddr(pte, va, st)));
    @(negedge clk);
    chk(rspValid == 1'b0 && reqReady == 1'b1, "R8 single pulse, R2 ready again",
        {30'd0, rspValid, reqReady}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    chk(reqReady == 1'b1 && memReqValid == 1'b0 && rspValid == 1'b0,
        "R1 reset state", {29'd0, reqReady, memReqValid, rspValid}, 32'h4);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk(reqReady == 1'b1 && memReqValid == 1'b0 && rspValid == 1'b0,
        "R1 after release", {29'd0, reqReady, memReqValid, rspValid}, 32'h4);

    // R8: stray response while idle is ignored
    @(negedge clk);
    memRspValid = 1'b1; memRspData = 32'hFFFF_FFFF;
    @(negedge clk);
    memRspValid = 1'b0;
    chk(memReqValid == 1'b0 && rspValid == 1'b0 && reqReady == 1'b1,
        "R8 stray response ignored", {29'd0, reqReady, memReqValid, rspValid}, 32'h4);
    @(negedge clk);
    chk(rspValid == 1'b0, "R8 no pulse from stray", 32'(rspValid), 32'd0);

    // directed cases
    doTxn(32'h1234_5ABC, 2'b00, 1'b0, 24'h010000, 32'hABC0_0001, 0, 1'b0, "R7 ro read");
    doTxn(32'h0000_1FFF, 2'b01, 1'b1, 24'h020000, 32'h0000_0006, 2, 1'b0,
          "R4 page fault priority");
    doTxn(32'hFFFF_F123, 2'b00, 1'b0, 24'hFFFFF0, 32'h5550_000B, 1, 1'b0, "R3 wrap");
    doTxn(32'h0040_0777, 2'b01, 1'b0, 24'h000100, 32'h1230_0001, 0, 1'b0, "R5 write ro");
    doTxn(32'h0040_0777, 2'b10, 1'b1, 24'h000100, 32'h1230_000D, 3, 1'b0, "R5 exec xo");
    doTxn(32'h0040_0777, 2'b00, 1'b0, 24'h000100, 32'h1230_0007, 0, 1'b0, "R5 rights 11");
    doTxn(32'h0040_0777, 2'b11, 1'b0, 24'h000100, 32'h1230_0003, 0, 1'b0, "R5 access 11");
    doTxn(32'h0080_0001, 2'b01, 1'b1, 24'h000200, 32'h7770_0003, 1, 1'b0, "R6 user kpage");
    doTxn(32'h0080_0001, 2'b01, 1'b0, 24'h000200, 32'h7770_0003, 1, 1'b0, "R6 kernel kpage");
    doTxn(32'h0123_4567, 2'b00, 1'b1, 24'h003000, 32'h9990_0009, 4, 1'b1, "R2 busy req");

    // random
    for (int n = 0; n < 300; n++) begin
      doTxn($urandom, 2'($urandom), 1'($urandom), 24'($urandom), $urandom,
            int'($urandom % 4), 1'($urandom), "random");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule